// File: doc/BRIEF.md
# Auxiliary-Channel Request Frame Builder

This block turns one auxiliary-channel request into the byte stream that a downstream serializer sends on the wire. A request carries a 4-bit command, a 20-bit target address, a payload length and a defer delay. The block packs a three-byte header from the command and address, appends a length byte when the length is nonzero, and for write commands forwards the payload bytes arriving on a streaming input straight after the header. Bytes leave one per cycle on a valid/ready output stream that feeds the serializer's transmit buffer.

Once the whole frame has been handed over, the block acknowledges the serializer's done flag with a one-cycle pulse, waits until that flag reads clear, counts out a start delay of ten cycles per defer unit and then pulses go for one cycle. The total number of bytes the serializer must send is held on a count output for the whole transaction. Requests longer than the payload limit are refused with an error pulse and produce no bytes and no go.

All three streams (request, payload, transmit) follow the usual rule: a transfer happens on a clock edge where valid and ready are both high. The transmit output never withdraws or changes a byte while it waits for ready; in the payload phase the output mirrors the payload input, so the payload source must likewise hold its byte until it is taken. The request input is ready only while the block is idle; payload ready is high only during the payload phase of a write and then equals transmit ready.

Top module: `aux_req_framer`

## Requirements
- R1: The first byte sent has the command in bits 7:4 and address bits 19:16 in bits 3:0; the second byte is address bits 15:8 and the third is address bits 7:0.
- R2: When the length is nonzero a fourth header byte equal to length minus one follows; when the length is zero the header is exactly three bytes.
- R3: Commands 4'b1000 (native write), 4'b0000 (I2C write) and 4'b0100 (I2C write, transaction kept open) are writes: their payload bytes follow the header in arrival order. Every other command is a read: no payload byte is sent and payload ready stays low for the whole transaction.
- R4: The frame length output equals the header size (3 or 4) plus the length for writes only; it is valid from the cycle after a request is accepted until the next acceptance, and equals the number of bytes actually handed over.
- R5: While transmit valid is high and transmit ready is low, valid stays high and the byte stays unchanged (given a payload source that obeys the same rule); payload ready equals transmit ready during the payload phase.
- R6: A request whose length exceeds 16 makes err high for exactly one cycle, the cycle after acceptance; no byte is sent, no done acknowledge or go follows, and the block is ready again.
- R7: In the cycle after the last byte is taken, done_ack is high for exactly one cycle; the block then waits for as long as done_in is high.
- R8: With D = defer times 10, go is high for exactly one cycle, D+2 cycles after the first cycle following done_ack in which done_in is low; with done_in already low that is D+3 cycles after done_ack.
- R9: Request ready is high only while idle, so no new request is accepted between acceptance and the go (or err) pulse.
- R10: After reset the block is idle: request ready high, and transmit valid, payload ready, done_ack, go and err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken when high with req_valid |
| req_cmd | input | 4 | Request command code |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Payload length in bytes (0 to 16 legal) |
| req_defer | input | 8 | Start delay in units of 10 cycles |
| pl_valid | input | 1 | Payload byte offered |
| pl_ready | output | 1 | Payload byte taken when high with pl_valid |
| pl_data | input | 8 | Payload byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Transmit buffer accepts the byte |
| tx_data | output | 8 | Transmit byte |
| frame_len | output | 5 | Total bytes the serializer must send |
| done_in | input | 1 | Serializer done flag |
| done_ack | output | 1 | One-cycle acknowledge of the done flag |
| go | output | 1 | One-cycle start pulse to the serializer |
| err | output | 1 | One-cycle pulse for a refused request |

## Verification
A wrong byte index shows at once as a misplaced or missing header byte on the transmit stream, and a wrong write decode shows as payload ready rising on a read or a write frame that ends before its payload. A corrupted frame length or lost byte count shows when the frame closes, as a done_ack that arrives early or late and a count output that disagrees with the bytes taken. A fault in the wait or delay logic shows only at the end of the transaction, as a go pulse off its expected cycle, so the bench measures go against both done_ack and the release of done_in under several delays and back-pressure patterns.

// File: rtl/aux_frm_pkg.sv
package aux_frm_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_HDR  = 3'd1,
    S_PAY  = 3'd2,
    S_ACK  = 3'd3,
    S_WAIT = 3'd4,
    S_DLY  = 3'd5,
    S_GO   = 3'd6
  } frm_state_t;

  localparam logic [3:0] CMD_NATIVE_WR = 4'b1000;
  localparam logic [3:0] CMD_I2C_WR    = 4'b0000;
  localparam logic [3:0] CMD_I2C_WR_OP = 4'b0100;

  function automatic logic frm_is_write(input logic [3:0] cmd);
    return (cmd == CMD_NATIVE_WR) || (cmd == CMD_I2C_WR) || (cmd == CMD_I2C_WR_OP);
  endfunction

endpackage

// File: rtl/aux_frm_hdr.sv
module aux_frm_hdr
  import aux_frm_pkg::*;
#(
  parameter int LEN_W  = 5,
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 5
) (
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [CNT_W-1:0]  sel,
  output logic [7:0]        byte_out,
  output logic [CNT_W-1:0]  hdr_n,
  output logic [CNT_W-1:0]  total,
  output logic              is_wr
);
  localparam int SLOTS = 4;

  logic [7:0] slot [SLOTS];
  logic [7:0] len_m1;

  assign len_m1 = 8'(len) - 8'd1;

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      if (g == 0) begin : g_cmd
        assign slot[g] = {cmd, addr[19:16]};
      end else if (g == 1) begin : g_mid
        assign slot[g] = addr[15:8];
      end else if (g == 2) begin : g_low
        assign slot[g] = addr[7:0];
      end else begin : g_len
        assign slot[g] = len_m1;
      end
    end
  endgenerate

  always_comb begin
    byte_out = 8'h00;
    for (int i = 0; i < SLOTS; i++) begin
      if (sel == CNT_W'(i)) byte_out = slot[i];
    end
  end

  assign is_wr = frm_is_write(cmd);
  assign hdr_n = (len != '0) ? CNT_W'(4) : CNT_W'(3);
  assign total = is_wr ? (hdr_n + CNT_W'(len)) : hdr_n;

endmodule

// File: rtl/aux_frm_delay.sv
module aux_frm_delay #(
  parameter int DEFER_W     = 8,
  parameter int DELAY_SCALE = 10,
  parameter int DLY_W       = DEFER_W + $clog2(DELAY_SCALE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DEFER_W-1:0] defer,
  output logic               expired
);
  logic [DLY_W-1:0] scaled;
  logic [DLY_W-1:0] cnt_q;

  generate
    if (DELAY_SCALE == 1) begin : g_unit
      assign scaled = DLY_W'(defer);
    end else begin : g_mul
      assign scaled = DLY_W'(defer) * DLY_W'(DELAY_SCALE);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= scaled;
    else if (cnt_q != '0)  cnt_q <= cnt_q - DLY_W'(1);
  end

  assign expired = (cnt_q == '0);

  AST_DELAY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(scaled)));  // R8

endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
  import aux_frm_pkg::*;
#(
  parameter int MAX_LEN     = 16,
  parameter int LEN_W       = 5,
  parameter int ADDR_W      = 20,
  parameter int DEFER_W     = 8,
  parameter int DELAY_SCALE = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [3:0]         req_cmd,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [DEFER_W-1:0] req_defer,
  input  logic               pl_valid,
  output logic               pl_ready,
  input  logic [7:0]         pl_data,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [7:0]         tx_data,
  output logic [LEN_W-1:0]   frame_len,
  input  logic               done_in,
  output logic               done_ack,
  output logic               go,
  output logic               err
);
  localparam int CNT_W = $clog2(MAX_LEN + 5);

  frm_state_t         state_q, state_d;
  logic [3:0]         cmd_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   len_q;
  logic [DEFER_W-1:0] defer_q;
  logic [CNT_W-1:0]   idx_q;
  logic               err_q;

  logic [7:0]         hdr_byte;
  logic [CNT_W-1:0]   hdr_n;
  logic [CNT_W-1:0]   total;
  logic               is_wr;
  logic               dly_load;
  logic               dly_done;

  logic accept, too_long, take;

  aux_frm_hdr #(
    .LEN_W (LEN_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_hdr (
    .cmd     (cmd_q),
    .addr    (addr_q),
    .len     (len_q),
    .sel     (idx_q),
    .byte_out(hdr_byte),
    .hdr_n   (hdr_n),
    .total   (total),
    .is_wr   (is_wr)
  );

  aux_frm_delay #(
    .DEFER_W    (DEFER_W),
    .DELAY_SCALE(DELAY_SCALE)
  ) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (dly_load),
    .defer  (defer_q),
    .expired(dly_done)
  );

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign too_long  = (req_len > LEN_W'(MAX_LEN));

  always_comb begin
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    pl_ready = 1'b0;
    case (state_q)
      S_HDR: begin
        tx_valid = 1'b1;
        tx_data  = hdr_byte;
      end
      S_PAY: begin
        tx_valid = pl_valid;
        tx_data  = pl_data;
        pl_ready = tx_ready;
      end
      default: ;
    endcase
  end

  assign take     = tx_valid && tx_ready;
  assign dly_load = (state_q == S_WAIT) && !done_in;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (accept && !too_long) state_d = S_HDR;
      S_HDR: begin
        if (take && (idx_q == hdr_n - CNT_W'(1))) begin
          state_d = (is_wr && (len_q != '0)) ? S_PAY : S_ACK;
        end
      end
      S_PAY:  if (take && (idx_q == total - CNT_W'(1))) state_d = S_ACK;
      S_ACK:  state_d = S_WAIT;
      S_WAIT: if (!done_in) state_d = S_DLY;
      S_DLY:  if (dly_done) state_d = S_GO;
      S_GO:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      defer_q <= '0;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= accept && too_long;
      if (accept && !too_long) begin
        cmd_q   <= req_cmd;
        addr_q  <= req_addr;
        len_q   <= req_len;
        defer_q <= req_defer;
        idx_q   <= '0;
      end else if (take) begin
        idx_q <= idx_q + CNT_W'(1);
      end
    end
  end

  assign frame_len = LEN_W'(total);
  assign done_ack  = (state_q == S_ACK);
  assign go        = (state_q == S_GO);
  assign err       = err_q;

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);  // R8
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_ack |=> !done_ack && !go);  // R7
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && state_q == S_HDR) |=> tx_valid && $stable(tx_data));  // R5
  AST_GO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (CNT_W'(frame_len) == idx_q));  // R4
  AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && too_long) |=> err && req_ready);  // R6
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !tx_valid && !pl_ready && !go);  // R9

endmodule

// File: tb/sim_aux_req_framer.sv
`timescale 1ns/1ps
module sim_aux_req_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_cmd = '0;
  logic [19:0] req_addr = '0;
  logic [4:0]  req_len = '0;
  logic [7:0]  req_defer = '0;
  logic        pl_valid = 1'b0;
  logic        pl_ready;
  logic [7:0]  pl_data = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic [4:0]  frame_len;
  logic        done_in = 1'b0;
  logic        done_ack;
  logic        go;
  logic        err;

  always #2 clk = ~clk;

  aux_req_framer u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len), .req_defer(req_defer),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .frame_len(frame_len), .done_in(done_in), .done_ack(done_ack),
    .go(go), .err(err)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  // monitor state
  logic [7:0] cap [32];
  int  cap_n, pl_ptr, go_n, go_cyc, ack_n, ack_cyc, err_n, rel_cyc, hold_left;
  bit  read_frame, active, bp;
  logic [7:0] pl_buf [32];
  int  pl_pend;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_wr(input logic [3:0] c);
    return (c == 4'b1000) || (c == 4'b0000) || (c == 4'b0100);
  endfunction

  function automatic int exp_hdr(input int len);
    return (len != 0) ? 4 : 3;
  endfunction

  function automatic int exp_total(input logic [3:0] c, input int len);
    return exp_hdr(len) + (exp_wr(c) ? len : 0);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [3:0] c, input logic [19:0] a,
                                          input int len, input int i);
    if (i == 0) return {c, a[19:16]};
    if (i == 1) return a[15:8];
    if (i == 2) return a[7:0];
    if (i == 3 && len != 0) return 8'(len - 1);
    return pl_buf[i - exp_hdr(len)];
  endfunction

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // Drive stream inputs at negedge, then sample settled outputs.
  initial forever begin
    @(negedge clk);
    if (ack_n > 0 && hold_left > 0) begin
      hold_left--;
      if (hold_left == 0) begin
        done_in = 1'b0;
        rel_cyc = cyc;
      end
    end else if (hold_left > 0) begin
      done_in = 1'b1;
    end
    tx_ready = bp ? (($urandom % 3) != 0) : 1'b1;
    if (pl_pend == 0) pl_valid = bp ? (($urandom % 2) == 1) : 1'b1;
    pl_data = pl_buf[pl_ptr];
    #1;
    if (active) begin
      if (tx_valid && tx_ready && cap_n < 32) begin
        cap[cap_n] = tx_data;
        cap_n++;
      end
      if (pl_valid && !pl_ready) pl_pend = 1;
      if (pl_valid && pl_ready) begin
        pl_ptr++;
        pl_pend = 0;
      end
      if (read_frame && pl_ready)
        chk(1'b0, "R3 pl_ready high on read", 1, 0);
      if (done_ack) begin
        ack_n++;
        if (ack_cyc < 0) ack_cyc = cyc;
      end
      if (go) begin
        go_n++;
        if (go_cyc < 0) go_cyc = cyc;
      end
      if (err) err_n++;
    end
  end

  task automatic do_req(input logic [3:0] c, input logic [19:0] a, input int len,
                        input int defer, input int hold, input bit bpress);
    int tot, d, exp_go;
    bit rej;
    rej = (len > 16);
    for (int i = 0; i < 32; i++) pl_buf[i] = 8'($urandom);
    cap_n = 0; pl_ptr = 0; pl_pend = 0; go_n = 0; go_cyc = -1; ack_n = 0; ack_cyc = -1;
    err_n = 0; rel_cyc = -1; hold_left = hold; bp = bpress;
    read_frame = !exp_wr(c);
    active = 1;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_len = 5'(len); req_defer = 8'(defer);
    @(negedge clk);
    req_valid = 1'b0;
    for (int w = 0; w < 4000; w++) begin
      if (go_n > 0 || (rej && w > 20)) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    active = 0;
    #1;
    if (rej) begin
      chk(err_n == 1, "R6 err pulse count", err_n, 1);
      chk(cap_n == 0 && go_n == 0 && ack_n == 0, "R6 no bytes/go", cap_n + go_n, 0);
      chk(req_ready == 1'b1, "R6 ready again", req_ready, 1);
      return;
    end
    tot = exp_total(c, len);
    d = defer * 10;
    chk(err_n == 0, "R6 no err on legal length", err_n, 0);
    chk(int'(frame_len) == tot, "R4 frame_len", frame_len, tot);
    chk(cap_n == tot, "R4 bytes handed over", cap_n, tot);
    for (int i = 0; i < tot && i < cap_n; i++) begin
      logic [7:0] e;
      e = exp_byte(c, a, len, i);
      if (i < 3) chk(cap[i] == e, "R1 header byte", cap[i], e);
      else if (i == 3 && len != 0) chk(cap[i] == e, "R2 length byte", cap[i], e);
      else chk(cap[i] == e, "R3 payload byte", cap[i], e);
    end
    chk(pl_ptr == (exp_wr(c) ? len : 0), "R3 payload bytes taken", pl_ptr, exp_wr(c) ? len : 0);
    chk(ack_n == 1, "R7 done_ack single pulse", ack_n, 1);
    chk(go_n == 1, "R8 go single pulse", go_n, 1);
    exp_go = (hold == 0) ? (ack_cyc + 3 + d) : (rel_cyc + 2 + d);
    chk(go_cyc == exp_go, "R8 go cycle", go_cyc, exp_go);
    chk(req_ready == 1'b1, "R9 idle after go", req_ready, 1);
  endtask

  initial begin
    bit dummy;
    dummy = 1'($urandom(32'h5eed_1234));
    hold_left = 0; active = 0; bp = 0; pl_pend = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R10 req_ready", req_ready, 1);
    chk(!tx_valid && !pl_ready, "R10 streams idle", tx_valid + pl_ready, 0);
    chk(!done_ack && !go && !err, "R10 pulses low", done_ack + go + err, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
    // R9: ready stays low mid-frame
    // directed corner cases
    do_req(4'b1000, 20'hA5C3E, 16, 0, 0, 1);   // R3 native write, max payload
    do_req(4'b1001, 20'h12345, 0, 1, 0, 0);    // R2 read, zero length
    do_req(4'b0000, 20'hFFFFF, 0, 0, 2, 1);    // R2 write, zero length, done held
    do_req(4'b0100, 20'h00F0F, 5, 2, 3, 1);    // R3 I2C write, open transaction
    do_req(4'b0101, 20'h8_0001, 7, 0, 0, 1);   // R3 I2C read with length
    do_req(4'b1000, 20'h33333, 17, 0, 0, 0);   // R6 just over limit
    do_req(4'b1001, 20'h44444, 31, 0, 0, 0);   // R6 far over limit
    do_req(4'b0000, 20'h0ABCD, 1, 3, 1, 1);    // R2 length one, byte 3 = 0
    for (int n = 0; n < 40; n++) begin
      do_req(4'($urandom), 20'($urandom), int'($urandom % 18), int'($urandom % 4),
             int'($urandom % 4), 1'($urandom));
    end
    // R9: a second request is held off while a frame is in flight
    active = 1; cap_n = 0; hold_left = 0; bp = 0; go_n = 0; ack_n = 0; go_cyc = -1;
    ack_cyc = -1; err_n = 0; read_frame = 1;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 4'b1001; req_addr = 20'h1; req_len = 5'd2; req_defer = 8'd1;
    @(negedge clk);
    #1;
    chk(req_ready == 1'b0, "R9 ready low in frame", req_ready, 0);
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    active = 0;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule